// File: doc/BRIEF.md
# Prioritising Interrupt Distributor with CPU Routing

This block gathers interrupt requests from peripheral lines and from software writes, keeps a pending state for each one, and for every attached CPU presents the single most urgent interrupt that is enabled, pending and routed to that CPU. Each output channel carries the winning ID, its priority and its group bit. The CPU takes it by pulsing its acknowledge input, which consumes the pending event.

IDs are split into three classes. IDs 0 to 15 are software-raised and always edge-type. IDs 16 to 31 are private peripheral lines and always level-type. Both of these classes are banked: each CPU has its own copy of enable, group, priority and pending state. On the register port, the `cpu_sel` input selects which copy an access reaches. IDs from 32 up to `NUM_IRQ-1` are shared. Each shared ID has a selectable trigger type and a writable byte that routes it to CPUs.

A flat register port does configuration. A write happens in the cycle when `wr_en` is high. Reads are combinational from `addr`. The address is `{region[3:0], index}`. `NUM_IRQ` must be a multiple of 32 in the range 64 to 1020, and `NUM_CPU` must be between 1 and 8.

Top module: `irqd_top`

## Requirements
- R1: IDs 0-15 are software-raised and IDs 16-31 are private lines (ID 16+k of CPU c is `ppi_i[c*16+k]`). Both classes keep enable, group, priority and pending state separately per CPU, and a register access reaches the copy of CPU `cpu_sel`. IDs 32 and above are shared (ID 32+k is `spi_i[k]`) and have one copy of their state.
- R2: A CPU with no candidate gets `irq_valid`=0 and `irq_id`=1023. A reported ID is always below `NUM_IRQ`, so 1020-1023 never appear as a real interrupt.
- R3: The trigger region (region 7) holds two bits per ID at bits [2k+1:2k] of word `idx`, where ID = idx*16+k. Software-raised IDs always read 2'b10, private IDs always read 2'b01, and writes to either leave them unchanged.
- R4: For shared IDs, trigger bit 0 always reads 1. Bit 1 set to 0 selects active-high level, which is the reset value; bit 1 set to 1 selects rising edge. A level interrupt is pending while its line is high and not yet acknowledged. After an acknowledge it stays clear until the line has gone low.
- R5: The target region (region 6) holds byte k of word `idx` for ID = idx*4+k. For a shared ID, bit n of that byte routes it to CPU n. For IDs below 32 the byte reads as the one-hot code of `cpu_sel` and ignores writes.
- R6: A candidate is an interrupt that is pending, enabled and routed to the CPU. The candidate with the numerically lowest priority byte (region 5, laid out like the target region) wins. Among equal priorities, the lowest ID wins.
- R7: An edge interrupt becomes pending on a rising edge of its line. Further edges while it is pending add nothing, and one acknowledge clears it.
- R8: Region 0 sets and region 1 clears enable bits, with bit b of word `idx` standing for ID idx*32+b; a 0 bit has no effect. Regions 2 and 3 set and clear pending bits the same way for edge-type IDs. All four regions read back the current state.
- R9: A write to region 8 raises software interrupt `wdata[3:0]` as pending in the bank of every CPU n whose bit `wdata[8+n]` is 1.
- R10: After reset everything is disabled, ungrouped, at priority 0 and not pending. Each output shows the winner's ID, priority and group in the cycle after the clock edge that changed the state.
- R11: The group region (region 4) stores one group bit per ID, laid out as in R8, and the winner's bit appears on `irq_grp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4+log2(NUM_IRQ/4) | Region in the top 4 bits, word index below |
| wdata | input | 32 | Write data |
| cpu_sel | input | log2(NUM_CPU) | CPU whose banked copy an access reaches |
| rdata | output | 32 | Combinational read data for `addr` |
| ppi_i | input | NUM_CPU*16 | Private interrupt lines, 16 per CPU |
| spi_i | input | NUM_IRQ-32 | Shared interrupt lines |
| ack_i | input | NUM_CPU | Per-CPU acknowledge of the presented ID |
| irq_valid | output | NUM_CPU | A candidate exists for the CPU |
| irq_id | output | NUM_CPU*10 | Winning ID per CPU, 1023 when none |
| irq_prio | output | NUM_CPU*8 | Winning priority per CPU, 0xFF when none |
| irq_grp | output | NUM_CPU | Winning group bit per CPU |

## Verification
A wrong pending or enable bit shows on the ports one cycle after the edge that caused it. The affected CPU then presents the wrong ID, or loses its valid, and that can be seen at the next sample. A wrong hold bit on a level source shows up as a CPU that is offered the same interrupt again right after acknowledging it. A banking error shows as one CPU's write or software interrupt appearing on another CPU's channel. The directed tasks look for these effects on the channel of the CPU concerned and also on a neighbouring channel that must not change.

// File: rtl/irqd_pkg.sv
// Shared definitions for the interrupt distributor: register regions and
// the mapping between (CPU, ID) pairs and flat state slots.
// Assumes banked IDs occupy slots 0..NUM_CPU*32-1, shared IDs follow.
package irqd_pkg;

    localparam int          BANKED_IDS = 32;
    localparam int          SGI_IDS    = 16;
    localparam logic [9:0]  ID_NONE    = 10'd1023;

    typedef enum logic [3:0] {
        RG_EN_SET  = 4'd0,
        RG_EN_CLR  = 4'd1,
        RG_PD_SET  = 4'd2,
        RG_PD_CLR  = 4'd3,
        RG_GROUP   = 4'd4,
        RG_PRIO    = 4'd5,
        RG_TARGET  = 4'd6,
        RG_TRIG    = 4'd7,
        RG_SGI     = 4'd8
    } region_e;

    // Slot holding the state of ID 'id' as seen by CPU 'cpu'.
    function automatic int slot_of(input int cpu, input int id, input int ncpu);
        return (id < BANKED_IDS) ? cpu * BANKED_IDS + id : ncpu * BANKED_IDS + id - BANKED_IDS;
    endfunction

    // Interrupt ID stored in slot 's'.
    function automatic int slot_id(input int s, input int ncpu);
        return (s < ncpu * BANKED_IDS) ? s % BANKED_IDS : s - ncpu * BANKED_IDS + BANKED_IDS;
    endfunction

    // Owning CPU of slot 's', or -1 for a shared slot.
    function automatic int slot_bank(input int s, input int ncpu);
        return (s < ncpu * BANKED_IDS) ? s / BANKED_IDS : -1;
    endfunction

endpackage

// File: rtl/irqd_slot.sv
// State of one interrupt in one bank: enable, group, priority and pending.
// Edge sources latch a rising edge or a software set until cleared or
// acknowledged; level sources follow the line, masked after an acknowledge
// until the line falls. Assumes decoded write strobes from the parent.
module irqd_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_set_i,
    input  logic       en_clr_i,
    input  logic       grp_we_i,
    input  logic       grp_d_i,
    input  logic       prio_we_i,
    input  logic [7:0] prio_d_i,
    input  logic       edge_i,
    input  logic       line_i,
    input  logic       pd_set_i,
    input  logic       pd_clr_i,
    input  logic       ack_i,
    output logic       en_o,
    output logic       grp_o,
    output logic [7:0] prio_o,
    output logic       pend_o
);

    logic line_q;
    logic held_q;
    logic rise;

    assign rise = line_i & ~line_q;

    // Configuration bits written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            grp_o  <= 1'b0;
            prio_o <= 8'h00;
        end else begin
            if (en_set_i)       en_o <= 1'b1;
            else if (en_clr_i)  en_o <= 1'b0;
            if (grp_we_i)       grp_o  <= grp_d_i;
            if (prio_we_i)      prio_o <= prio_d_i;
        end
    end

    // Pending tracking for edge and level trigger types.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            held_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            line_q <= line_i;
            if (edge_i) begin
                held_q <= 1'b0;
                pend_o <= rise | pd_set_i | (pend_o & ~(pd_clr_i | ack_i));
            end else begin
                held_q <= line_i & (held_q | ack_i);
                pend_o <= line_i & ~(held_q | ack_i);
            end
        end
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i && pend_o && !pd_clr_i && !ack_i |=> pend_o);              // R7
    AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i && ack_i && !pd_set_i && !rise |=> !pend_o);               // R7
    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i && !line_i |=> !pend_o);                                  // R4
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i && ack_i |=> !pend_o);                                    // R4
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> en_o);                                               // R8

endmodule

// File: rtl/irqd_pick.sv
// Per-CPU winner selection: lowest priority value among candidates,
// lowest ID on ties. Purely combinational; ID_NONE when nothing qualifies.
module irqd_pick import irqd_pkg::*; #(
    parameter int N = 64
) (
    input  logic [N-1:0]   cand_i,
    input  logic [N*8-1:0] prio_i,
    input  logic [N-1:0]   grp_i,
    output logic           valid_o,
    output logic [9:0]     id_o,
    output logic [7:0]     prio_o,
    output logic           grp_o
);

    localparam int IW = $clog2(N);

    logic          found;
    logic [IW-1:0] best;
    logic [7:0]    best_p;

    // Linear scan; strict less-than keeps the lower ID on equal priority.
    always_comb begin
        found  = 1'b0;
        best   = '0;
        best_p = 8'hFF;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!found || prio_i[i*8 +: 8] < best_p)) begin
                found  = 1'b1;
                best   = IW'(i);
                best_p = prio_i[i*8 +: 8];
            end
        end
        valid_o = found;
        id_o    = found ? 10'(best) : ID_NONE;
        prio_o  = best_p;
        grp_o   = found & grp_i[best];
    end

endmodule

// File: rtl/irqd_top.sv
// Interrupt distributor top: banked and shared interrupt state, trigger and
// routing configuration for shared IDs, per-CPU winner selection and the
// word-addressed register port. Assumes NUM_IRQ is a multiple of 32 in
// 64..1020 and NUM_CPU is 1..8.
module irqd_top import irqd_pkg::*; #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int IDX_W  = $clog2(NUM_IRQ / 4),
    localparam int AW     = 4 + IDX_W,
    localparam int CW     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    input  logic [CW-1:0]         cpu_sel,
    output logic [31:0]           rdata,
    input  logic [NUM_CPU*16-1:0] ppi_i,
    input  logic [NUM_IRQ-33:0]   spi_i,
    input  logic [NUM_CPU-1:0]    ack_i,
    output logic [NUM_CPU-1:0]    irq_valid,
    output logic [NUM_CPU*10-1:0] irq_id,
    output logic [NUM_CPU*8-1:0]  irq_prio,
    output logic [NUM_CPU-1:0]    irq_grp
);

    localparam int NSLOT = NUM_CPU * BANKED_IDS + NUM_IRQ - BANKED_IDS;
    localparam int IW    = $clog2(NUM_IRQ);

    logic [3:0]       rg;
    logic [IDX_W-1:0] rg_idx;
    assign rg     = addr[AW-1 -: 4];
    assign rg_idx = addr[IDX_W-1:0];

    logic       en_w   [NSLOT];
    logic       grp_w  [NSLOT];
    logic [7:0] prio_w [NSLOT];
    logic       pend_w [NSLOT];
    logic       edge_w [NSLOT];
    logic [7:0] tgt_w  [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int              SID   = slot_id(s, NUM_CPU);
        localparam int              SBANK = slot_bank(s, NUM_CPU);
        localparam bit              SSH   = (SBANK < 0);
        localparam logic [CW-1:0]   SCPU  = CW'(SSH ? 0 : SBANK);

        logic mine, w32, w4, w16, line, sgi_hit, ack_hit;

        assign mine = wr_en && (SSH || cpu_sel == SCPU);
        assign w32  = mine && rg_idx == IDX_W'(SID / 32);
        assign w4   = mine && rg_idx == IDX_W'(SID / 4);
        assign w16  = mine && rg_idx == IDX_W'(SID / 16);

        if (SID < SGI_IDS) begin : g_sgi
            assign line      = 1'b0;
            assign edge_w[s] = 1'b1;
            assign tgt_w[s]  = 8'(1 << SBANK);
            assign sgi_hit   = wr_en && rg == RG_SGI && wdata[3:0] == 4'(SID) && wdata[8 + SBANK];
        end else if (SID < BANKED_IDS) begin : g_ppi
            assign line      = ppi_i[SBANK*16 + SID - SGI_IDS];
            assign edge_w[s] = 1'b0;
            assign tgt_w[s]  = 8'(1 << SBANK);
            assign sgi_hit   = 1'b0;
        end else begin : g_spi
            logic       edge_q;
            logic [7:0] tgt_q;
            assign line      = spi_i[SID - BANKED_IDS];
            assign edge_w[s] = edge_q;
            assign tgt_w[s]  = tgt_q;
            assign sgi_hit   = 1'b0;
            // Trigger type and CPU routing byte of a shared ID.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    edge_q <= 1'b0;
                    tgt_q  <= 8'h00;
                end else begin
                    if (w16 && rg == RG_TRIG)   edge_q <= wdata[2*(SID % 16) + 1];
                    if (w4  && rg == RG_TARGET) tgt_q  <= wdata[8*(SID % 4) +: 8];
                end
            end
        end

        if (SSH) begin : g_ack_sh
            // Any CPU acknowledging this shared ID consumes it.
            always_comb begin
                ack_hit = 1'b0;
                for (int c = 0; c < NUM_CPU; c++)
                    if (ack_i[c] && irq_valid[c] && irq_id[c*10 +: 10] == 10'(SID))
                        ack_hit = 1'b1;
            end
        end else begin : g_ack_bk
            assign ack_hit = ack_i[SBANK] && irq_valid[SBANK] && irq_id[SBANK*10 +: 10] == 10'(SID);
        end

        irqd_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_set_i  (w32 && rg == RG_EN_SET && wdata[SID % 32]),
            .en_clr_i  (w32 && rg == RG_EN_CLR && wdata[SID % 32]),
            .grp_we_i  (w32 && rg == RG_GROUP),
            .grp_d_i   (wdata[SID % 32]),
            .prio_we_i (w4 && rg == RG_PRIO),
            .prio_d_i  (wdata[8*(SID % 4) +: 8]),
            .edge_i    (edge_w[s]),
            .line_i    (line),
            .pd_set_i  ((w32 && rg == RG_PD_SET && wdata[SID % 32]) || sgi_hit),
            .pd_clr_i  (w32 && rg == RG_PD_CLR && wdata[SID % 32]),
            .ack_i     (ack_hit),
            .en_o      (en_w[s]),
            .grp_o     (grp_w[s]),
            .prio_o    (prio_w[s]),
            .pend_o    (pend_w[s])
        );
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_IRQ-1:0]   cand;
        logic [NUM_IRQ*8-1:0] prio_v;
        logic [NUM_IRQ-1:0]   grp_v;

        // Gather this CPU's view of every ID from banked or shared slots.
        always_comb begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                cand[i]          = pend_w[slot_of(c, i, NUM_CPU)] & en_w[slot_of(c, i, NUM_CPU)]
                                 & tgt_w[slot_of(c, i, NUM_CPU)][c];
                prio_v[i*8 +: 8] = prio_w[slot_of(c, i, NUM_CPU)];
                grp_v[i]         = grp_w[slot_of(c, i, NUM_CPU)];
            end
        end

        irqd_pick #(.N(NUM_IRQ)) u_pick (
            .cand_i  (cand),
            .prio_i  (prio_v),
            .grp_i   (grp_v),
            .valid_o (irq_valid[c]),
            .id_o    (irq_id[c*10 +: 10]),
            .prio_o  (irq_prio[c*8 +: 8]),
            .grp_o   (irq_grp[c])
        );

        AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_valid[c] |-> irq_id[c*10 +: 10] < 10'(NUM_IRQ));          // R2
        AST_WIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_valid[c] |-> cand[irq_id[c*10 +: IW]]);                   // R6
    end

    // Combinational read-back of the region and word selected by addr.
    always_comb begin
        rdata = 32'h0;
        if (int'(cpu_sel) < NUM_CPU) begin
            case (rg)
                RG_EN_SET, RG_EN_CLR, RG_PD_SET, RG_PD_CLR, RG_GROUP: begin
                    for (int b = 0; b < 32; b++) begin
                        if (int'(rg_idx) * 32 + b < NUM_IRQ) begin
                            if (rg == RG_GROUP)
                                rdata[b] = grp_w[slot_of(int'(cpu_sel), int'(rg_idx) * 32 + b, NUM_CPU)];
                            else if (rg == RG_EN_SET || rg == RG_EN_CLR)
                                rdata[b] = en_w[slot_of(int'(cpu_sel), int'(rg_idx) * 32 + b, NUM_CPU)];
                            else
                                rdata[b] = pend_w[slot_of(int'(cpu_sel), int'(rg_idx) * 32 + b, NUM_CPU)];
                        end
                    end
                end
                RG_PRIO, RG_TARGET: begin
                    for (int k = 0; k < 4; k++) begin
                        if (int'(rg_idx) * 4 + k < NUM_IRQ) begin
                            if (rg == RG_PRIO)
                                rdata[8*k +: 8] = prio_w[slot_of(int'(cpu_sel), int'(rg_idx) * 4 + k, NUM_CPU)];
                            else
                                rdata[8*k +: 8] = tgt_w[slot_of(int'(cpu_sel), int'(rg_idx) * 4 + k, NUM_CPU)];
                        end
                    end
                end
                RG_TRIG: begin
                    for (int k = 0; k < 16; k++) begin
                        if (int'(rg_idx) * 16 + k < SGI_IDS)
                            rdata[2*k +: 2] = 2'b10;
                        else if (int'(rg_idx) * 16 + k < BANKED_IDS)
                            rdata[2*k +: 2] = 2'b01;
                        else if (int'(rg_idx) * 16 + k < NUM_IRQ)
                            rdata[2*k +: 2] = {edge_w[slot_of(0, int'(rg_idx) * 16 + k, NUM_CPU)], 1'b1};
                    end
                end
                default: rdata = 32'h0;
            endcase
        end
    end

endmodule

// File: tb/irqd_top_bench.sv
`timescale 1ns/1ps
module irqd_top_bench;

    localparam int NUM_IRQ = 64;
    localparam int NUM_CPU = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = 8'h0;
    logic [31:0]  wdata = 32'h0;
    logic [1:0]   cpu_sel = 2'd0;
    logic [31:0]  rdata;
    logic [63:0]  ppi_i = '0;
    logic [31:0]  spi_i = '0;
    logic [3:0]   ack_i = '0;
    logic [3:0]   irq_valid;
    logic [39:0]  irq_id;
    logic [31:0]  irq_prio;
    logic [3:0]   irq_grp;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    irqd_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_irqd_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cpu_sel(cpu_sel), .rdata(rdata), .ppi_i(ppi_i), .spi_i(spi_i),
        .ack_i(ack_i), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_prio(irq_prio), .irq_grp(irq_grp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] r, input int i, input logic [31:0] d, input int cpu);
        @(negedge clk);
        wr_en = 1'b1; addr = {r, 4'(i)}; wdata = d; cpu_sel = 2'(cpu);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] r, input int i, input int cpu, output logic [31:0] d);
        addr = {r, 4'(i)}; cpu_sel = 2'(cpu);
        #1 d = rdata;
    endtask

    task automatic ack(input int c);
        ack_i[c] = 1'b1;
        tick();
        ack_i[c] = 1'b0;
    endtask

    function automatic logic [31:0] cid(input int c);
        return {22'h0, irq_id[c*10 +: 10]};
    endfunction

    task automatic off_all();
        for (int c = 0; c < NUM_CPU; c++) begin
            wr(4'd1, 0, 32'hFFFF_FFFF, c);
            wr(4'd1, 1, 32'hFFFF_FFFF, c);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 reset valid", {28'h0, irq_valid}, 32'h0);
        chk("R2 idle id cpu0", cid(0), 32'd1023);
        chk("R2 idle id cpu3", cid(3), 32'd1023);
        rd(4'd7, 0, 0, d); chk("R3 sgi trigger code", d, 32'hAAAA_AAAA);
        rd(4'd7, 1, 0, d); chk("R3 ppi trigger code", d, 32'h5555_5555);
        rd(4'd7, 2, 0, d); chk("R4 shared default level", d, 32'h5555_5555);
        rd(4'd5, 8, 0, d); chk("R10 reset priority", d, 32'h0);
    endtask

    task automatic t_trig();
        logic [31:0] d;
        wr(4'd7, 0, 32'h0, 0);          rd(4'd7, 0, 0, d); chk("R3 sgi code fixed", d, 32'hAAAA_AAAA);
        wr(4'd7, 1, 32'hFFFF_FFFF, 0);  rd(4'd7, 1, 0, d); chk("R3 ppi code fixed", d, 32'h5555_5555);
        wr(4'd7, 2, 32'h0, 0);          rd(4'd7, 2, 0, d); chk("R4 low bit reads one", d, 32'h5555_5555);
        wr(4'd7, 2, 32'hFFFF_FFFF, 0);  rd(4'd7, 2, 0, d); chk("R4 edge select", d, 32'hFFFF_FFFF);
        wr(4'd7, 2, 32'h5555_5555, 0);
    endtask

    task automatic t_target();
        logic [31:0] d;
        rd(4'd6, 0, 2, d); chk("R5 banked target", d, 32'h0404_0404);
        wr(4'd6, 0, 32'hFFFF_FFFF, 2);
        rd(4'd6, 0, 2, d); chk("R5 banked target ro", d, 32'h0404_0404);
        rd(4'd6, 4, 1, d); chk("R5 ppi target cpu1", d, 32'h0202_0202);
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(4'd6, 8, 32'h0000_0200, 0);
        wr(4'd5, 8, 32'h0000_1000, 0);
        wr(4'd0, 1, 32'h0000_0002, 0);
        spi_i[1] = 1'b1; tick();
        chk("R6 level id cpu1", cid(1), 32'd33);
        chk("R10 level prio", {24'h0, irq_prio[15:8]}, 32'h10);
        chk("R5 not routed cpu0", {31'h0, irq_valid[0]}, 32'h0);
        rd(4'd2, 1, 0, d); chk("R8 pending readback", d, 32'h0000_0002);
        ack(1);
        chk("R4 held after ack", {31'h0, irq_valid[1]}, 32'h0);
        tick();
        chk("R4 still held", {31'h0, irq_valid[1]}, 32'h0);
        spi_i[1] = 1'b0; tick();
        spi_i[1] = 1'b1; tick();
        chk("R4 re-arm after low", cid(1), 32'd33);
        spi_i[1] = 1'b0; tick();
        chk("R4 follows line low", {31'h0, irq_valid[1]}, 32'h0);
        off_all();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(4'd6, 8, 32'h0101_0000, 0);
        wr(4'd5, 8, 32'h4080_0000, 0);
        wr(4'd0, 1, 32'h0000_000C, 0);
        spi_i[2] = 1'b1; spi_i[3] = 1'b1; tick();
        chk("R6 lower value wins", cid(0), 32'd35);
        chk("R6 winner prio", {24'h0, irq_prio[7:0]}, 32'h40);
        wr(4'd5, 8, 32'h4040_0000, 0);
        chk("R6 tie lowest id", cid(0), 32'd34);
        wr(4'd4, 1, 32'h0000_0004, 0);
        chk("R11 group out", {31'h0, irq_grp[0]}, 32'h1);
        rd(4'd4, 1, 0, d); chk("R11 group readback", d, 32'h0000_0004);
        wr(4'd1, 1, 32'h0, 0);
        chk("R8 clear zero no effect", cid(0), 32'd34);
        wr(4'd1, 1, 32'h0000_0004, 0);
        chk("R8 clear enable", cid(0), 32'd35);
        spi_i[2] = 1'b0; spi_i[3] = 1'b0;
        off_all();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(4'd7, 2, 32'h5557_5555, 0);
        wr(4'd6, 10, 32'h0000_0003, 0);
        wr(4'd0, 1, 32'h0000_0100, 0);
        for (int k = 0; k < 3; k++) begin
            spi_i[8] = 1'b1; tick();
            spi_i[8] = 1'b0; tick();
        end
        chk("R7 edge pend cpu0", cid(0), 32'd40);
        chk("R5 two-cpu route", cid(1), 32'd40);
        ack(0);
        chk("R7 one ack clears cpu0", {31'h0, irq_valid[0]}, 32'h0);
        chk("R7 one ack clears cpu1", {31'h0, irq_valid[1]}, 32'h0);
        tick();
        chk("R7 no replay", {31'h0, irq_valid[0]}, 32'h0);
        spi_i[8] = 1'b1; tick(); spi_i[8] = 1'b0; tick();
        chk("R7 new edge", cid(0), 32'd40);
        wr(4'd3, 1, 32'h0000_0100, 0);
        chk("R8 pend clear", {31'h0, irq_valid[0]}, 32'h0);
        wr(4'd2, 1, 32'h0000_0100, 0);
        chk("R8 pend set", cid(1), 32'd40);
        rd(4'd2, 1, 0, d); chk("R8 pend set readback", d, 32'h0000_0100);
        wr(4'd3, 1, 32'h0000_0100, 0);
        off_all();
    endtask

    task automatic t_sgi();
        for (int c = 0; c < 3; c++) wr(4'd0, 0, 32'h0000_0020, c);
        wr(4'd8, 0, 32'h0000_0505, 0);
        chk("R9 sgi cpu0", cid(0), 32'd5);
        chk("R9 sgi cpu2", cid(2), 32'd5);
        chk("R9 sgi cpu1 untouched", {31'h0, irq_valid[1]}, 32'h0);
        wr(4'd1, 0, 32'h0, 0);
        chk("R8 zero clear no effect", cid(0), 32'd5);
        wr(4'd1, 0, 32'h0000_0020, 0);
        chk("R8 bank0 disabled", {31'h0, irq_valid[0]}, 32'h0);
        chk("R1 bank2 unaffected", cid(2), 32'd5);
        wr(4'd3, 0, 32'h0000_0020, 2);
        chk("R8 bank2 pend clear", {31'h0, irq_valid[2]}, 32'h0);
        wr(4'd2, 0, 32'h0000_0020, 1);
        chk("R1 bank1 pend set", cid(1), 32'd5);
        chk("R1 bank2 still clear", {31'h0, irq_valid[2]}, 32'h0);
        ack(1);
        chk("R7 sgi ack", {31'h0, irq_valid[1]}, 32'h0);
        off_all();
    endtask

    task automatic t_ppi();
        wr(4'd0, 0, 32'h0004_0000, 3);
        wr(4'd0, 0, 32'h0004_0000, 0);
        ppi_i[50] = 1'b1; tick();
        chk("R1 ppi cpu3", cid(3), 32'd18);
        chk("R1 ppi not cpu0", {31'h0, irq_valid[0]}, 32'h0);
        ack(3);
        chk("R4 ppi held", {31'h0, irq_valid[3]}, 32'h0);
        ppi_i[50] = 1'b0; tick();
        chk("R2 idle after all", cid(3), 32'd1023);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_trig();
        t_target();
        t_level();
        t_prio();
        t_edge();
        t_sgi();
        t_ppi();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule